// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a fixed set of interrupt inputs for one processor and raises a single request line whenever some enabled, pending source outranks the level now being serviced. Source 0 is the fast-interrupt input; it is enabled, prioritised and acknowledged exactly like the others. Each source has a 3-bit priority and can be either level-sensitive (its pending flag follows its input) or edge-triggered (a rising input edge latches the flag).

Software talks to the block through a small word-addressed register port with single-cycle read and write strobes. Reading the vector register acknowledges the winning source: its number plus one is returned, and its level is pushed onto an internal stack of nested levels. Writing the end-of-service register pops that stack. A read with nothing worth servicing returns zero and leaves the stack alone. In debug mode a vector read only takes a snapshot, and the stack is updated when the vector register is later written.

Top module: `aic_ctrl`

## Requirements
- R1: Writing a 1 to bit n of the enable-set register (address 8) enables source n, writing a 1 to bit n of the enable-clear register (address 9) disables it, and the mask status register (address 10) reads back the enable bits; after reset every source is disabled, the stack is empty and debug mode is off.
- R2: A disabled source never raises irq_o and is never returned by a vector read, whatever its input or pending state.
- R3: Per-source configuration lives at address n (n < 8): bits [2:0] priority, bit 4 edge mode. For an edge source a rising input sets its pending flag, a 1 in the pending-set register (address 11) sets it and a 1 in the pending-clear register (address 12) clears it; for a level source those two writes have no effect and the pending status register (address 17) shows the input.
- R4: irq_o is high exactly when the best enabled pending source has priority strictly above the current level, an empty stack counting as below priority 0.
- R5: Among enabled pending sources the highest priority wins; equal priorities go to the lowest source number.
- R6: In normal mode a vector read (address 13) while irq_o is high returns the winning source number plus one, pushes it, and clears its pending flag if it is edge-triggered. The current-source register (address 16) reads the source on top of the stack in bits [3:0] and the stack depth in bits [11:8].
- R7: A vector read while irq_o is low returns zero and leaves the stack and current-source register unchanged.
- R8: Writing the end-of-service register (address 14) pops one level, restoring the previous source and level; on an empty stack it has no effect.
- R9: With debug mode on (address 15, bit 0) a vector read returns the same value but changes no state; a later write of any value to the vector register pushes the source captured by that read and clears its edge pending flag, and does nothing if that read returned zero.
- R10: While a level is being serviced, sources of equal or lower priority do not raise irq_o; a strictly higher one does and nests on top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Interrupt inputs, bit 0 is the fast source |
| bus_rd | input | 1 | Register read strobe, side effects at the clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is the debug-mode window between the capturing read and the committing write, where the stack, the pending flag and irq_o must all look untouched. The bench makes edge sources pending through the pending-set register rather than input timing, so it can read the vector, inspect the current-source and pending registers inside that window, and then commit. Deep nesting is reached the same way, raising higher-priority sources one at a time and unwinding them with end-of-service writes down to and past an empty stack.

// File: rtl/aic_pkg.sv
// Shared constants of the interrupt controller: register map and field positions.
// Assumes at most 8 sources and a priority field of at most 4 bits.
package aic_pkg;
    localparam int REG_ADDR_W = 5;
    localparam int EDGE_BIT   = 4;   // edge-mode bit inside a configuration word
    localparam int DEPTH_LSB  = 8;   // depth field inside the current-source word

    localparam logic [REG_ADDR_W-1:0] A_ENSET = 5'd8;
    localparam logic [REG_ADDR_W-1:0] A_ENCLR = 5'd9;
    localparam logic [REG_ADDR_W-1:0] A_MASK  = 5'd10;
    localparam logic [REG_ADDR_W-1:0] A_PSET  = 5'd11;
    localparam logic [REG_ADDR_W-1:0] A_PCLR  = 5'd12;
    localparam logic [REG_ADDR_W-1:0] A_VEC   = 5'd13;
    localparam logic [REG_ADDR_W-1:0] A_EOS   = 5'd14;
    localparam logic [REG_ADDR_W-1:0] A_CTRL  = 5'd15;
    localparam logic [REG_ADDR_W-1:0] A_CUR   = 5'd16;
    localparam logic [REG_ADDR_W-1:0] A_PEND  = 5'd17;
endpackage

// File: rtl/aic_pending.sv
// Pending flags, one per source. Level sources show their input directly;
// edge sources latch a rising input or a software set, and drop on a software
// clear or an acknowledge. A set in the same cycle as a clear wins.
// Assumes inputs are already synchronous to clk.
module aic_pending #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_i,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] set_cmd,
    input  logic [NSRC-1:0] clr_cmd,
    input  logic [NSRC-1:0] ack,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic rise;
        assign rise = irq_i[i] & ~prev_q[i];

        // Track last input value and the latched edge flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                flag_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= irq_i[i];
                if (edge_mode[i])
                    flag_q[i] <= (flag_q[i] & ~(clr_cmd[i] | ack[i])) | rise | set_cmd[i];
                else
                    flag_q[i] <= 1'b0;
            end
        end

        assign pend_o[i] = edge_mode[i] ? flag_q[i] : irq_i[i];
    end
endmodule

// File: rtl/aic_arbiter.sv
// Picks the winning request: highest priority, lowest index on a tie.
// Purely combinational; a linear scan whose depth grows with NSRC.
module aic_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]   req,
    input  logic [PRIO_W-1:0] prio [NSRC],
    output logic              vld_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [PRIO_W-1:0] prio_o
);
    // Scan upward; a later source replaces the choice only when strictly higher.
    always_comb begin
        vld_o  = 1'b0;
        src_o  = '0;
        prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!vld_o || prio[i] > prio_o)) begin
                vld_o  = 1'b1;
                src_o  = SRC_W'(i);
                prio_o = prio[i];
            end
        end
    end
endmodule

// File: rtl/aic_prio_stack.sv
// Stack of serviced (source, priority) pairs. The top gives the current level,
// encoded as priority+1, with 0 for an empty stack. Callers push only strictly
// higher levels, so DEPTH = number of priority values suffices.
module aic_prio_stack #(
    parameter int SRC_W  = 3,
    parameter int PRIO_W = 3,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int IW    = $clog2(DEPTH),
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SRC_W-1:0]  push_src,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [DW-1:0]     depth_o,
    output logic [SRC_W-1:0]  top_src_o,
    output logic [PRIO_W:0]   lvl_o
);
    logic [SRC_W-1:0]  src_q  [DEPTH];
    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [DW-1:0]     depth_q;
    logic [IW-1:0]     top_idx;

    // Push writes the slot above the top; pop just lowers the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                src_q[i]  <= '0;
                prio_q[i] <= '0;
            end
        end else if (push && depth_q < DW'(DEPTH)) begin
            src_q[IW'(depth_q)]  <= push_src;
            prio_q[IW'(depth_q)] <= push_prio;
            depth_q              <= depth_q + 1'b1;
        end else if (pop && depth_q != '0) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    assign top_idx   = IW'(depth_q - 1'b1);
    assign depth_o   = depth_q;
    assign top_src_o = (depth_q == '0) ? '0 : src_q[top_idx];
    assign lvl_o     = (depth_q == '0) ? '0 : ({1'b0, prio_q[top_idx]} + 1'b1);
endmodule

// File: rtl/aic_ctrl.sv
// Top of the nested priority interrupt controller: register file, vector
// acknowledge (immediate in normal mode, deferred to a vector write in debug
// mode), end-of-service pop and request generation.
// Assumes one bus access per cycle (bus_rd and bus_wr never both high),
// NSRC <= 8 and PRIO_W <= 4.
module aic_ctrl
    import aic_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       irq_i,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o
);
    localparam int SRC_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int STK_DEPTH = 1 << PRIO_W;
    localparam int DW        = $clog2(STK_DEPTH + 1);

    logic [PRIO_W-1:0] cfg_prio [NSRC];
    logic [NSRC-1:0]   cfg_edge;
    logic [NSRC-1:0]   en_q;
    logic              dbg_q;
    logic              snap_vld;
    logic [SRC_W-1:0]  snap_src;
    logic [PRIO_W-1:0] snap_prio;

    logic              cfg_hit;
    logic [SRC_W-1:0]  cfg_idx;
    logic [NSRC-1:0]   wdata_src;
    logic              unused_wdata;
    logic [NSRC-1:0]   pset, pclr, ack, pend;
    logic              best_vld;
    logic [SRC_W-1:0]  best_src;
    logic [PRIO_W-1:0] best_prio;
    logic [PRIO_W:0]   best_lvl, cur_lvl;
    logic              rd_vec, wr_vec, push_norm, push_dbg, push, pop;
    logic [SRC_W-1:0]  push_src;
    logic [PRIO_W-1:0] push_prio;
    logic [DW-1:0]     stk_depth;
    logic [SRC_W-1:0]  top_src;

    assign cfg_hit      = int'(bus_addr) < NSRC;
    assign cfg_idx      = SRC_W'(bus_addr);
    assign wdata_src    = bus_wdata[NSRC-1:0];
    assign unused_wdata = ^bus_wdata;

    // Per-source configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) cfg_prio[i] <= '0;
            cfg_edge <= '0;
        end else if (bus_wr && cfg_hit) begin
            cfg_prio[cfg_idx] <= bus_wdata[PRIO_W-1:0];
            cfg_edge[cfg_idx] <= bus_wdata[EDGE_BIT];
        end
    end

    // Enable mask via separate set and clear command addresses; debug mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dbg_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_ENSET) en_q  <= en_q | wdata_src;
            if (bus_addr == A_ENCLR) en_q  <= en_q & ~wdata_src;
            if (bus_addr == A_CTRL)  dbg_q <= bus_wdata[0];
        end
    end

    assign pset = (bus_wr && bus_addr == A_PSET) ? wdata_src : '0;
    assign pclr = (bus_wr && bus_addr == A_PCLR) ? wdata_src : '0;

    aic_pending #(.NSRC(NSRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .edge_mode (cfg_edge),
        .set_cmd   (pset),
        .clr_cmd   (pclr),
        .ack       (ack),
        .pend_o    (pend)
    );

    aic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .req    (pend & en_q),
        .prio   (cfg_prio),
        .vld_o  (best_vld),
        .src_o  (best_src),
        .prio_o (best_prio)
    );

    assign best_lvl = {1'b0, best_prio} + 1'b1;
    assign irq_o    = best_vld && (best_lvl > cur_lvl);

    assign rd_vec    = bus_rd && bus_addr == A_VEC;
    assign wr_vec    = bus_wr && bus_addr == A_VEC;
    assign push_norm = rd_vec && !dbg_q && irq_o;
    assign push_dbg  = wr_vec && dbg_q && snap_vld;
    assign push      = push_norm || push_dbg;
    assign push_src  = push_dbg ? snap_src  : best_src;
    assign push_prio = push_dbg ? snap_prio : best_prio;
    assign pop       = bus_wr && bus_addr == A_EOS;
    assign ack       = push ? (NSRC'(1) << push_src) : '0;

    // Debug-mode snapshot: captured on a vector read, consumed by a vector write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_vld  <= 1'b0;
            snap_src  <= '0;
            snap_prio <= '0;
        end else if (rd_vec && dbg_q) begin
            snap_vld  <= irq_o;
            snap_src  <= best_src;
            snap_prio <= best_prio;
        end else if (wr_vec) begin
            snap_vld  <= 1'b0;
        end
    end

    aic_prio_stack #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_src  (push_src),
        .push_prio (push_prio),
        .pop       (pop),
        .depth_o   (stk_depth),
        .top_src_o (top_src),
        .lvl_o     (cur_lvl)
    );

    // Read data multiplexer, combinational on the address.
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata[PRIO_W-1:0] = cfg_prio[cfg_idx];
            bus_rdata[EDGE_BIT]   = cfg_edge[cfg_idx];
        end else begin
            case (bus_addr)
                A_VEC:   if (irq_o) bus_rdata = DATA_W'(best_src) + 1'b1;
                A_MASK:  bus_rdata[NSRC-1:0] = en_q;
                A_PEND:  bus_rdata[NSRC-1:0] = pend;
                A_CUR: begin
                    bus_rdata[SRC_W-1:0]          = top_src;
                    bus_rdata[DEPTH_LSB +: DW]    = stk_depth;
                end
                A_CTRL:  bus_rdata[0] = dbg_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/aic_ctrl_chk.sv
// Protocol checker for aic_ctrl, attached by bind. Observes the bus, the
// request line and the enable and stack state.
module aic_ctrl_chk
    import aic_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int DATA_W = 32,
    parameter int DW     = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  irq_o,
    input logic [NSRC-1:0]       en_q,
    input logic                  dbg_q,
    input logic [DW-1:0]         depth
);
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENSET) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R1
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENCLR) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R1
    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o); // R2
    AST_SPUR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_VEC && !irq_o) |-> (bus_rdata == '0)); // R7
    AST_SPUR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC && !irq_o) |=> $stable(depth)); // R7
    AST_PUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC && !dbg_q && irq_o) |=> (depth == $past(depth) + DW'(1))); // R6
    AST_EOS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOS && depth != '0) |=> (depth == $past(depth) - DW'(1))); // R8
    AST_DBG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC && dbg_q) |=> $stable(depth)); // R9
endmodule

bind aic_ctrl aic_ctrl_chk #(.NSRC(NSRC), .DATA_W(DATA_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .dbg_q     (dbg_q),
    .depth     (stk_depth)
);

// File: tb/sim_aic_ctrl.sv
`timescale 1ns/1ps
module sim_aic_ctrl;
    localparam int NSRC = 8;
    localparam int DW32 = 32;

    localparam logic [1:0] OP_N = 2'd0, OP_W = 2'd1, OP_R = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [4:0]  addr;
        logic [31:0] data;   // write data or expected read data
        logic [7:0]  irq;
        logic        xirq;   // expected irq_o after the step
    } step_t;

    localparam int NSTEP = 19;
    localparam step_t TBL [NSTEP] = '{
        '{OP_R, 4'd1,  5'd10, 32'h0,     8'h00, 1'b0},  // R1 mask clear after reset
        '{OP_W, 4'd3,  5'd2,  32'h5,     8'h00, 1'b0},  // R3 src2 level prio5
        '{OP_W, 4'd3,  5'd5,  32'h5,     8'h00, 1'b0},  // R3 src5 level prio5
        '{OP_W, 4'd1,  5'd8,  32'h24,    8'h00, 1'b0},  // R1 enable src2, src5
        '{OP_R, 4'd1,  5'd10, 32'h24,    8'h00, 1'b0},  // R1 mask readback
        '{OP_N, 4'd4,  5'd0,  32'h0,     8'h20, 1'b1},  // R4 src5 raises request
        '{OP_N, 4'd4,  5'd0,  32'h0,     8'h24, 1'b1},  // R4 both pending
        '{OP_R, 4'd5,  5'd13, 32'h3,     8'h24, 1'b0},  // R5 tie goes to src2; R10 src5 blocked
        '{OP_R, 4'd6,  5'd16, 32'h102,   8'h24, 1'b0},  // R6 depth 1, src2
        '{OP_R, 4'd7,  5'd13, 32'h0,     8'h24, 1'b0},  // R7 spurious read
        '{OP_R, 4'd7,  5'd16, 32'h102,   8'h24, 1'b0},  // R7 stack unchanged
        '{OP_W, 4'd8,  5'd14, 32'h0,     8'h24, 1'b1},  // R8 pop re-raises request
        '{OP_R, 4'd8,  5'd16, 32'h0,     8'h24, 1'b1},  // R8 stack empty
        '{OP_W, 4'd2,  5'd9,  32'h04,    8'h24, 1'b1},  // R2 disable src2
        '{OP_R, 4'd1,  5'd10, 32'h20,    8'h24, 1'b1},  // R1 mask after clear
        '{OP_R, 4'd2,  5'd13, 32'h6,     8'h24, 1'b0},  // R2 disabled src2 skipped
        '{OP_W, 4'd8,  5'd14, 32'h0,     8'h24, 1'b1},  // R8 pop
        '{OP_W, 4'd2,  5'd9,  32'h20,    8'h24, 1'b0},  // R2 all disabled
        '{OP_R, 4'd2,  5'd13, 32'h0,     8'h24, 1'b0}   // R2 nothing returned
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NSRC-1:0]   irq_i;
    logic              bus_rd, bus_wr;
    logic [4:0]        bus_addr;
    logic [DW32-1:0]   bus_wdata;
    logic [DW32-1:0]   bus_rdata;
    logic              irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    aic_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(tag, {31'b0, irq_o}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_i = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1 reset request low");
        rd(5'd16, 32'h0, "R1 reset stack empty");

        // Table walk.
        for (int k = 0; k < NSTEP; k++) begin
            string tg;
            tg = $sformatf("R%0d step %0d", TBL[k].req, k);
            irq_i = TBL[k].irq;
            case (TBL[k].op)
                OP_W:    wr(TBL[k].addr, TBL[k].data);
                OP_R:    rd(TBL[k].addr, TBL[k].data, tg);
                default: @(negedge clk);
            endcase
            chk_irq(TBL[k].xirq, tg);
        end
        irq_i = '0;
        @(negedge clk);

        // R3: edge source, input pulse, set/clear commands.
        wr(5'd3, 32'h13);                        // src3 edge prio3
        wr(5'd8, 32'h08);
        irq_i = 8'h08; @(negedge clk); irq_i = '0;
        chk_irq(1'b1, "R3 rising edge latched");
        rd(5'd17, 32'h08, "R3 pending after pulse");
        wr(5'd12, 32'h08);
        rd(5'd17, 32'h00, "R3 pending clear");
        chk_irq(1'b0, "R3 request drops");
        wr(5'd11, 32'h08);
        chk_irq(1'b1, "R3 pending set");
        rd(5'd13, 32'h4, "R6 vector src3");
        rd(5'd17, 32'h00, "R6 edge flag auto-cleared");
        rd(5'd16, 32'h103, "R6 current source");
        wr(5'd14, 32'h0);
        wr(5'd11, 32'h20);                       // src5 is level, input low
        rd(5'd17, 32'h00, "R3 set ignored on level source");
        irq_i = 8'h20; @(negedge clk);
        wr(5'd12, 32'h20);
        rd(5'd17, 32'h20, "R3 clear ignored on level source");
        irq_i = '0; @(negedge clk);

        // R10 / R8: nesting and unwinding.
        wr(5'd1, 32'h16);                        // src1 edge prio6
        wr(5'd8, 32'h02);
        wr(5'd11, 32'h08);
        rd(5'd13, 32'h4, "R10 first level src3");
        chk_irq(1'b0, "R10 idle after first ack");
        wr(5'd11, 32'h02);
        chk_irq(1'b1, "R10 higher source preempts");
        rd(5'd13, 32'h2, "R10 nested vector src1");
        rd(5'd16, 32'h201, "R10 depth 2 on src1");
        wr(5'd11, 32'h08);
        chk_irq(1'b0, "R10 lower source held off");
        wr(5'd14, 32'h0);
        rd(5'd16, 32'h103, "R8 restored src3");
        chk_irq(1'b0, "R10 equal level held off");
        wr(5'd14, 32'h0);
        rd(5'd16, 32'h0, "R8 back to empty");
        chk_irq(1'b1, "R8 pending src3 re-raises");
        rd(5'd13, 32'h4, "R6 ack src3 again");
        wr(5'd14, 32'h0);
        wr(5'd14, 32'h0);
        rd(5'd16, 32'h0, "R8 pop on empty ignored");

        // R9: debug mode.
        wr(5'd15, 32'h1);
        wr(5'd11, 32'h08);
        rd(5'd13, 32'h4, "R9 debug read value");
        rd(5'd16, 32'h0, "R9 debug read no push");
        rd(5'd17, 32'h08, "R9 debug read keeps pending");
        chk_irq(1'b1, "R9 request still high");
        wr(5'd13, 32'hdead);
        rd(5'd16, 32'h103, "R9 write commits snapshot");
        rd(5'd17, 32'h00, "R9 commit clears edge flag");
        chk_irq(1'b0, "R9 request low after commit");
        wr(5'd14, 32'h0);
        rd(5'd13, 32'h0, "R7 debug spurious read");
        wr(5'd13, 32'h0);
        rd(5'd16, 32'h0, "R9 empty snapshot commits nothing");
        wr(5'd15, 32'h0);

        // R1: reset mid-run.
        wr(5'd11, 32'h08);
        rd(5'd13, 32'h4, "R6 ack before reset");
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(5'd10, 32'h0, "R1 mask after reset");
        rd(5'd16, 32'h0, "R1 stack after reset");
        rd(5'd15, 32'h0, "R1 debug off after reset");
        chk_irq(1'b0, "R1 request after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule